// File: doc/BRIEF.md
# Integer ALU with Instruction Decode

This block is the integer execution slice of a 32-bit load/store processor pipeline. It takes a raw instruction word together with the two source register values that the register file has already read. Without any clock, it produces the value to write back, the register index to write it to, a write strobe, an arithmetic overflow flag and an illegal-instruction flag.

A single decoder covers both instruction spaces. The first is the register-register space, where opcode 0 is followed by a function code. The second is the immediate space, opcodes 0x08 to 0x0F. For each operation the decoder picks where the destination index comes from and how the 16-bit immediate is widened. Trapping arithmetic and the two conditional moves can cancel the write even though the instruction is legal. The downstream exception logic uses the overflow and illegal flags. Shifts, multiply and divide, branches and memory access are handled by other units.

Top module: `ialu_top`

## Requirements
- R1: With opcode (bits 31:26) equal to 0, function codes (bits 5:0) 0x20, 0x21, 0x22 and 0x23 produce rs+rt, rs+rt, rs-rt and rs-rt respectively. Each result wraps modulo 2^32, and the destination is the rd field (bits 15:11).
- R2: With opcode 0, function codes 0x24, 0x25, 0x26 and 0x27 produce rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt) respectively.
- R3: Function codes 0x20 and 0x22 and opcode 0x08 assert the overflow flag and deassert write-enable on signed two's-complement overflow. Function codes 0x21 and 0x23 and opcode 0x09 never assert overflow.
- R4: Function code 0x2A produces 1 when rs < rt as signed numbers and 0 otherwise. Function code 0x2B does the same as unsigned numbers.
- R5: Opcodes 0x08 to 0x0E are add, add-unsigned, signed set-less-than, unsigned set-less-than, AND, OR and XOR of rs with the immediate in bits 15:0. The destination is the rt field (bits 20:16). The immediate is sign-extended for 0x08 to 0x0B and zero-extended for 0x0C to 0x0E.
- R6: Opcode 0x0B compares rs, as an unsigned number, against the sign-extended immediate, also taken as unsigned.
- R7: Opcode 0x0F produces the immediate in bits 31:16 and zeros in bits 15:0, whatever the rs value. Its destination is rt.
- R8: Function codes 0x0A and 0x0B produce rs with destination rd. Write-enable is set only when rt is zero (0x0A) or nonzero (0x0B).
- R9: Any other opcode, or any other function code under opcode 0, sets the illegal flag. In that case write-enable and overflow are 0, and the result and destination are 0.
- R10: Every legal instruction that is neither a conditional move nor an overflowing trapping operation sets write-enable, and the illegal flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| result_o | output | 32 | Value to write back |
| dest_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write-back enable |
| ovf_o | output | 1 | Signed overflow on a trapping operation |
| illegal_o | output | 1 | Instruction not in the supported set |

## Verification
The hardest cases to reach are overflow at the exact signed boundaries and the pairs of opcodes that differ only in trapping or in immediate extension. Uniformly random operands almost never land exactly on 0x7FFFFFFF+1, 0x80000000-1 or 0-0x80000000. The stimulus therefore draws operands from a pool weighted toward zero, one, all-ones and the two signed extremes, and it adds directed vectors at each boundary. Immediates with bit 15 set are directed at both the sign-extending and the zero-extending opcodes, and at the unsigned compare, where sign extension turns a small negative immediate into a huge unsigned bound. Conditional moves are driven with rt zero and rt nonzero in turn.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  localparam int INSN_W   = 32;
  localparam int REG_AW   = 5;
  localparam int IMM_W    = 16;
  localparam int OPC_LSB  = 26;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;
  localparam int FN_W     = 6;

  localparam logic [5:0] OPC_REGOP = 6'h00;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_ADD,
    OP_SUB,
    OP_AND,
    OP_OR,
    OP_XOR,
    OP_NOR,
    OP_SLT,
    OP_SLTU,
    OP_LUI,
    OP_MOVZ,
    OP_MOVN
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    trap;      // signed overflow cancels the write
    logic    use_imm;   // second operand is the immediate
    logic    imm_sign;  // sign-extend the immediate
    logic    dst_rt;    // destination is the rt field
    logic    illegal;
  } dec_t;

endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
  import ialu_pkg::*;
(
  input  logic [5:0]      opcode_i,
  input  logic [FN_W-1:0] funct_i,
  output dec_t            dec_o
);

  dec_t d;

  always_comb begin
    d.op       = OP_NONE;
    d.trap     = 1'b0;
    d.use_imm  = 1'b0;
    d.imm_sign = 1'b0;
    d.dst_rt   = 1'b0;
    d.illegal  = 1'b1;
    if (opcode_i == OPC_REGOP) begin
      d.illegal = 1'b0;
      unique case (funct_i)
        6'h20: begin d.op = OP_ADD; d.trap = 1'b1; end
        6'h21: d.op = OP_ADD;
        6'h22: begin d.op = OP_SUB; d.trap = 1'b1; end
        6'h23: d.op = OP_SUB;
        6'h24: d.op = OP_AND;
        6'h25: d.op = OP_OR;
        6'h26: d.op = OP_XOR;
        6'h27: d.op = OP_NOR;
        6'h2A: d.op = OP_SLT;
        6'h2B: d.op = OP_SLTU;
        6'h0A: d.op = OP_MOVZ;
        6'h0B: d.op = OP_MOVN;
        default: d.illegal = 1'b1;
      endcase
    end else begin
      d.illegal  = 1'b0;
      d.use_imm  = 1'b1;
      d.dst_rt   = 1'b1;
      unique case (opcode_i)
        6'h08: begin d.op = OP_ADD;  d.trap = 1'b1; d.imm_sign = 1'b1; end
        6'h09: begin d.op = OP_ADD;  d.imm_sign = 1'b1; end
        6'h0A: begin d.op = OP_SLT;  d.imm_sign = 1'b1; end
        6'h0B: begin d.op = OP_SLTU; d.imm_sign = 1'b1; end
        6'h0C: d.op = OP_AND;
        6'h0D: d.op = OP_OR;
        6'h0E: d.op = OP_XOR;
        6'h0F: d.op = OP_LUI;
        default: begin
          d.illegal = 1'b1;
          d.use_imm = 1'b0;
          d.dst_rt  = 1'b0;
        end
      endcase
    end
  end

  assign dec_o = d;

endmodule

// File: rtl/ialu_operand.sv
module ialu_operand
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  dec_t              dec_i,
  output logic [DATA_W-1:0] opb_o
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic              fill_bit;

  assign fill_bit = dec_i.imm_sign & imm_i[IMM_W-1];

  generate
    if (EXT_W > 0) begin : g_widen
      assign imm_ext = {{EXT_W{fill_bit}}, imm_i};
    end else begin : g_narrow
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign opb_o = dec_i.use_imm ? imm_ext : rt_val_i;

endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  dec_t              dec_i,
  output logic [DATA_W-1:0] result_o,
  output logic              ovf_raw_o
);

  localparam int MSB   = DATA_W - 1;
  localparam int LUI_W = DATA_W - IMM_W;

  logic              do_sub;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   sum_ext;
  logic [DATA_W-1:0] sum;
  logic              carry;
  logic              lt_signed;
  logic              lt_unsigned;
  logic [DATA_W-1:0] lui_val;

  // One adder serves add, subtract and both compares.
  assign do_sub  = (dec_i.op == OP_SUB) || (dec_i.op == OP_SLT) || (dec_i.op == OP_SLTU);
  assign addend  = do_sub ? ~opb_i : opb_i;
  assign sum_ext = {1'b0, opa_i} + {1'b0, addend} + {{DATA_W{1'b0}}, do_sub};
  assign sum     = sum_ext[DATA_W-1:0];
  assign carry   = sum_ext[DATA_W];

  assign ovf_raw_o   = (opa_i[MSB] == addend[MSB]) && (sum[MSB] != opa_i[MSB]);
  assign lt_signed   = sum[MSB] ^ ovf_raw_o;
  assign lt_unsigned = ~carry;

  generate
    if (LUI_W >= IMM_W) begin : g_lui_wide
      assign lui_val = {{(LUI_W-IMM_W){1'b0}}, imm_i, {IMM_W{1'b0}}};
    end else begin : g_lui_narrow
      assign lui_val = {imm_i[LUI_W-1:0], {IMM_W{1'b0}}};
    end
  endgenerate

  always_comb begin
    unique case (dec_i.op)
      OP_ADD, OP_SUB: result_o = sum;
      OP_AND:         result_o = opa_i & opb_i;
      OP_OR:          result_o = opa_i | opb_i;
      OP_XOR:         result_o = opa_i ^ opb_i;
      OP_NOR:         result_o = ~(opa_i | opb_i);
      OP_SLT:         result_o = {{(DATA_W-1){1'b0}}, lt_signed};
      OP_SLTU:        result_o = {{(DATA_W-1){1'b0}}, lt_unsigned};
      OP_LUI:         result_o = lui_val;
      OP_MOVZ,
      OP_MOVN:        result_o = opa_i;
      default:        result_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown(dec_i)) begin
      // R4: compares yield a single bit
      a_r4_slt_bool: assert (!((dec_i.op == OP_SLT) || (dec_i.op == OP_SLTU)) ||
                             (result_o[MSB:1] == '0))
        else $error("compare result not boolean");
      // R7: upper-immediate load clears the low half
      a_r7_lui_low_zero: assert ((dec_i.op != OP_LUI) || (result_o[IMM_W-1:0] == '0))
        else $error("upper-immediate low half not zero");
    end
  end

endmodule

// File: rtl/ialu_wb.sv
module ialu_wb
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  dec_t              dec_i,
  input  logic              ovf_raw_i,
  input  logic [DATA_W-1:0] rt_val_i,
  input  logic [REG_AW-1:0] rt_idx_i,
  input  logic [REG_AW-1:0] rd_idx_i,
  output logic [REG_AW-1:0] dest_o,
  output logic              wr_en_o,
  output logic              ovf_o
);

  logic rt_zero;
  logic cond_ok;

  assign rt_zero = (rt_val_i == '0);

  always_comb begin
    unique case (dec_i.op)
      OP_MOVZ: cond_ok = rt_zero;
      OP_MOVN: cond_ok = ~rt_zero;
      default: cond_ok = 1'b1;
    endcase
  end

  assign ovf_o   = dec_i.trap & ovf_raw_i;
  assign wr_en_o = ~dec_i.illegal & ~ovf_o & cond_ok;
  assign dest_o  = dec_i.illegal ? '0 : (dec_i.dst_rt ? rt_idx_i : rd_idx_i);

endmodule

// File: rtl/ialu_top.sv
module ialu_top
  import ialu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSN_W-1:0] insn_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [DATA_W-1:0] rt_val_i,
  output logic [DATA_W-1:0] result_o,
  output logic [REG_AW-1:0] dest_o,
  output logic              wr_en_o,
  output logic              ovf_o,
  output logic              illegal_o
);

  logic [5:0]        opcode;
  logic [FN_W-1:0]   funct;
  logic [IMM_W-1:0]  imm;
  logic [REG_AW-1:0] rt_idx;
  logic [REG_AW-1:0] rd_idx;
  logic              unused_fields;
  dec_t              dec;
  logic [DATA_W-1:0] opb;
  logic              ovf_raw;

  assign opcode        = insn_i[INSN_W-1:OPC_LSB];
  assign funct         = insn_i[FN_W-1:0];
  assign imm           = insn_i[IMM_W-1:0];
  assign rt_idx        = insn_i[RT_LSB +: REG_AW];
  assign rd_idx        = insn_i[RD_LSB +: REG_AW];
  assign unused_fields = ^insn_i[RS_LSB +: REG_AW];

  ialu_decode u_decode (
    .opcode_i (opcode),
    .funct_i  (funct),
    .dec_o    (dec)
  );

  ialu_operand #(.DATA_W(DATA_W)) u_operand (
    .rt_val_i (rt_val_i),
    .imm_i    (imm),
    .dec_i    (dec),
    .opb_o    (opb)
  );

  ialu_exec #(.DATA_W(DATA_W)) u_exec (
    .opa_i     (rs_val_i),
    .opb_i     (opb),
    .imm_i     (imm),
    .dec_i     (dec),
    .result_o  (result_o),
    .ovf_raw_o (ovf_raw)
  );

  ialu_wb #(.DATA_W(DATA_W)) u_wb (
    .dec_i     (dec),
    .ovf_raw_i (ovf_raw),
    .rt_val_i  (rt_val_i),
    .rt_idx_i  (rt_idx),
    .rd_idx_i  (rd_idx),
    .dest_o    (dest_o),
    .wr_en_o   (wr_en_o),
    .ovf_o     (ovf_o)
  );

  assign illegal_o = dec.illegal;

  always_comb begin
    if (!$isunknown({insn_i, rt_val_i})) begin
      // R9: illegal words leave no trace on the outputs
      a_r9_illegal_quiet: assert (!illegal_o || (!wr_en_o && !ovf_o && result_o == '0))
        else $error("illegal instruction not quiet");
      // R3: overflow always cancels the write
      a_r3_ovf_blocks_write: assert (!(ovf_o && wr_en_o))
        else $error("write despite overflow");
      // R3: non-trapping add/sub never flag overflow
      a_r3_no_overflow: assert (!(((opcode == OPC_REGOP) &&
                                   ((funct == 6'h21) || (funct == 6'h23))) ||
                                  (opcode == 6'h09)) || !ovf_o)
        else $error("overflow on non-trapping operation");
      // R8: move-if-zero with nonzero rt must not write
      a_r8_movz_hold: assert (!((opcode == OPC_REGOP) && (funct == 6'h0A) &&
                                (rt_val_i != '0)) || !wr_en_o)
        else $error("conditional move wrote");
    end
  end

endmodule

// File: tb/ialu_top_tb_top.sv
module ialu_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic        clk = 1'b0;
  logic [31:0] insn = 32'h0;
  logic [31:0] rs_val = 32'h0;
  logic [31:0] rt_val = 32'h0;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        wr_en, ovf, illegal;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ialu_top dut_i (
    .insn_i    (insn),
    .rs_val_i  (rs_val),
    .rt_val_i  (rt_val),
    .result_o  (result),
    .dest_o    (dest),
    .wr_en_o   (wr_en),
    .ovf_o     (ovf),
    .illegal_o (illegal)
  );

  function automatic logic [31:0] rtype(input logic [5:0] fn, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [4:0] rd);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] im);
    return {op, rs, rt, im};
  endfunction

  function automatic bit sovf(input longint s);
    return (s > SMAX) || (s < SMIN);
  endfunction

  task automatic model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic [4:0] d, output bit we,
                       output bit ov, output bit il, output string tag);
    logic [5:0]  op = w[31:26];
    logic [5:0]  fn = w[5:0];
    logic [31:0] sx = {{16{w[15]}}, w[15:0]};
    logic [31:0] zx = {16'h0, w[15:0]};
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint si = longint'($signed(sx));
    r = 32'h0; d = 5'd0; we = 1'b0; ov = 1'b0; il = 1'b1; tag = "R9";
    if (op == 6'h00) begin
      il = 1'b0; d = w[15:11]; we = 1'b1;
      case (fn)
        6'h20: begin r = a + b; ov = sovf(sa + sb); tag = "R3"; end
        6'h21: begin r = a + b; tag = "R1"; end
        6'h22: begin r = a - b; ov = sovf(sa - sb); tag = "R3"; end
        6'h23: begin r = a - b; tag = "R1"; end
        6'h24: begin r = a & b; tag = "R2"; end
        6'h25: begin r = a | b; tag = "R2"; end
        6'h26: begin r = a ^ b; tag = "R2"; end
        6'h27: begin r = ~(a | b); tag = "R2"; end
        6'h2A: begin r = (sa < sb) ? 32'd1 : 32'd0; tag = "R4"; end
        6'h2B: begin r = (a < b) ? 32'd1 : 32'd0; tag = "R4"; end
        6'h0A: begin r = a; we = (b == 0); tag = "R8"; end
        6'h0B: begin r = a; we = (b != 0); tag = "R8"; end
        default: begin il = 1'b1; d = 5'd0; we = 1'b0; tag = "R9"; end
      endcase
    end else begin
      il = 1'b0; d = w[20:16]; we = 1'b1; tag = "R5";
      case (op)
        6'h08: begin r = a + sx; ov = sovf(sa + si); tag = "R3"; end
        6'h09: r = a + sx;
        6'h0A: r = (sa < si) ? 32'd1 : 32'd0;
        6'h0B: begin r = (a < sx) ? 32'd1 : 32'd0; tag = "R6"; end
        6'h0C: r = a & zx;
        6'h0D: r = a | zx;
        6'h0E: r = a ^ zx;
        6'h0F: begin r = {w[15:0], 16'h0}; tag = "R7"; end
        default: begin il = 1'b1; d = 5'd0; we = 1'b0; tag = "R9"; end
      endcase
    end
    if (ov) we = 1'b0;
    if (!il && !ov && tag != "R8" && !we) tag = "R10";
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       input string note);
    logic [31:0] er;
    logic [4:0]  ed;
    bit          ewe, eov, eil;
    string       tag;
    @(posedge clk);
    insn = w; rs_val = a; rt_val = b;
    model(w, a, b, er, ed, ewe, eov, eil, tag);
    @(negedge clk);
    tests++;
    if (result !== er || dest !== ed || wr_en !== ewe || ovf !== eov || illegal !== eil) begin
      fails++;
      $display("FAIL %s %s insn=%h rs=%h rt=%h got res=%h dst=%0d we=%b ov=%b il=%b exp res=%h dst=%0d we=%b ov=%b il=%b",
               tag, note, w, a, b, result, dest, wr_en, ovf, illegal, er, ed, ewe, eov, eil);
    end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // idle word (function code 0) decodes as unsupported: R9
    apply(32'h0, 32'h0, 32'h0, "idle word R9");
    // R1 wrap-around arithmetic
    apply(rtype(6'h21, 1, 2, 3), 32'hFFFF_FFFF, 32'h2, "addu wrap R1");
    apply(rtype(6'h23, 1, 2, 9), 32'h0, 32'h1, "subu wrap R1");
    apply(rtype(6'h20, 1, 2, 4), 32'd100, 32'd23, "add plain R1");
    // R2 logic
    apply(rtype(6'h24, 1, 2, 5), 32'hF0F0_1234, 32'h0FF0_FF00, "and R2");
    apply(rtype(6'h25, 1, 2, 6), 32'hF0F0_1234, 32'h0FF0_FF00, "or R2");
    apply(rtype(6'h26, 1, 2, 7), 32'hF0F0_1234, 32'h0FF0_FF00, "xor R2");
    apply(rtype(6'h27, 1, 2, 8), 32'hF0F0_1234, 32'h0FF0_FF00, "nor R2");
    // R3 overflow boundaries
    apply(rtype(6'h20, 1, 2, 10), 32'h7FFF_FFFF, 32'h1, "add +ovf R3");
    apply(rtype(6'h20, 1, 2, 10), 32'h8000_0000, 32'hFFFF_FFFF, "add -ovf R3");
    apply(rtype(6'h22, 1, 2, 11), 32'h0, 32'h8000_0000, "sub 0-min R3");
    apply(rtype(6'h22, 1, 2, 11), 32'h8000_0000, 32'h1, "sub min-1 R3");
    apply(rtype(6'h22, 1, 2, 11), 32'hFFFF_FFFF, 32'h7FFF_FFFF, "sub no ovf R3");
    apply(rtype(6'h21, 1, 2, 12), 32'h7FFF_FFFF, 32'h1, "addu no trap R3");
    apply(rtype(6'h23, 1, 2, 12), 32'h8000_0000, 32'h1, "subu no trap R3");
    apply(itype(6'h08, 1, 13, 16'h0001), 32'h7FFF_FFFF, 32'h0, "addi ovf R3");
    apply(itype(6'h08, 1, 13, 16'hFFFF), 32'h8000_0000, 32'h0, "addi -ovf R3");
    apply(itype(6'h09, 1, 13, 16'h0001), 32'h7FFF_FFFF, 32'h0, "addiu no trap R3");
    // R4 compares
    apply(rtype(6'h2A, 1, 2, 14), 32'hFFFF_FFFF, 32'h1, "slt neg<pos R4");
    apply(rtype(6'h2B, 1, 2, 14), 32'hFFFF_FFFF, 32'h1, "sltu big R4");
    apply(rtype(6'h2A, 1, 2, 14), 32'h8000_0000, 32'h7FFF_FFFF, "slt extremes R4");
    apply(rtype(6'h2B, 1, 2, 14), 32'h5, 32'h5, "sltu equal R4");
    // R5 immediate extension
    apply(itype(6'h09, 1, 15, 16'h8000), 32'h0, 32'hDEAD, "addiu sext R5");
    apply(itype(6'h0C, 1, 16, 16'h8001), 32'hFFFF_FFFF, 32'h0, "andi zext R5");
    apply(itype(6'h0D, 1, 17, 16'hF00F), 32'h1234_0000, 32'h0, "ori zext R5");
    apply(itype(6'h0E, 1, 18, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, "xori zext R5");
    apply(itype(6'h0A, 1, 19, 16'hFFFF), 32'hFFFF_FFFE, 32'h0, "slti neg R5");
    // R6 unsigned compare vs sign-extended immediate
    apply(itype(6'h0B, 1, 20, 16'hFFFF), 32'h7000_0000, 32'h0, "sltiu huge bound R6");
    apply(itype(6'h0B, 1, 20, 16'hFFFF), 32'hFFFF_FFFF, 32'h0, "sltiu equal R6");
    // R7 upper immediate, rs ignored
    apply(itype(6'h0F, 7, 21, 16'hABCD), 32'h1234_5678, 32'h0, "lui R7");
    apply(itype(6'h0F, 0, 22, 16'h0000), 32'hFFFF_FFFF, 32'h0, "lui zero R7");
    // R8 conditional moves
    apply(rtype(6'h0A, 1, 2, 23), 32'hCAFE_F00D, 32'h0, "movz rt=0 R8");
    apply(rtype(6'h0A, 1, 2, 23), 32'hCAFE_F00D, 32'h4, "movz rt!=0 R8");
    apply(rtype(6'h0B, 1, 2, 24), 32'hCAFE_F00D, 32'h0, "movn rt=0 R8");
    apply(rtype(6'h0B, 1, 2, 24), 32'hCAFE_F00D, 32'h8000_0000, "movn rt!=0 R8");
    // R9 unsupported encodings
    apply(rtype(6'h28, 1, 2, 25), 32'h1, 32'h2, "funct 0x28 R9");
    apply(rtype(6'h2C, 1, 2, 25), 32'h1, 32'h2, "funct 0x2C R9");
    apply(itype(6'h07, 1, 2, 16'h1234), 32'h1, 32'h2, "opcode 0x07 R9");
    apply(itype(6'h23, 1, 2, 16'h1234), 32'h1, 32'h2, "opcode 0x23 R9");
    apply(itype(6'h10, 1, 2, 16'h1234), 32'h1, 32'h2, "opcode 0x10 R9");
    // R10 legal writes with rd/rt zero index too
    apply(rtype(6'h25, 3, 4, 0), 32'h1, 32'h2, "or to index0 R10");
    apply(itype(6'h0D, 3, 31, 16'h0), 32'h0, 32'h0, "ori to index31 R10");

    // weighted random sweep over all opcode classes
    for (int i = 0; i < 3000; i++) begin
      logic [5:0]  fns [12] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25,
                                6'h26, 6'h27, 6'h2A, 6'h2B, 6'h0A, 6'h0B};
      logic [31:0] w;
      logic [31:0] a = pick_val();
      logic [31:0] b = pick_val();
      logic [31:0] rnd = $urandom();
      case ($urandom_range(0, 9))
        0, 1, 2, 3: w = rtype(fns[$urandom_range(0, 11)], rnd[25:21], rnd[20:16], rnd[15:11]);
        4, 5, 6, 7: w = itype(6'(8 + $urandom_range(0, 7)), rnd[25:21], rnd[20:16],
                              ($urandom_range(0, 1) == 1) ? {1'b1, rnd[14:0]} : rnd[15:0]);
        default: w = $urandom();
      endcase
      apply(w, a, b, "random sweep");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule